// File: doc/BRIEF.md
# Processor Clock and Reset Conditioner

This block turns a fast oscillator into the clock for a small 8-bit-data microprocessor and conditions the two asynchronous control inputs the processor depends on. The oscillator is divided by three so that the processor clock is high for one oscillator period out of three. A second, slower clock for peripherals toggles on every falling edge of the processor clock, which gives half the processor frequency at an even duty cycle.

An active-high reset request asserts the reset output at once, without waiting for a clock edge. Release is held back by a stretch counter. The counter waits the larger of a fixed minimum number of processor clocks and a time-derived count, and then passes through a two-stage synchronizer. Reset therefore always leaves on a processor clock rising edge. A ready request from slow memory or I/O passes through its own two-stage synchronizer before it reaches the bus sequencer.

All flip-flops run on the oscillator. Any stage described as clocked by the processor clock updates only in the oscillator cycle whose edge is a rising edge of the processor clock. The reset request clears the divider, so the processor clock restarts from a known phase when the request is released.

Top module: `cpu_clkrst_cond`

## Requirements
- R1: While the reset request is low, the processor clock repeats every DIV_RATIO oscillator cycles and is high for exactly HIGH_STATES of them (defaults 3 and 1, giving a 33% duty cycle).
- R2: While the reset request is high, the processor clock is low. After the request is released, the processor clock first rises at the DIV_RATIO-th oscillator rising edge after the release.
- R3: The peripheral clock is low during the reset request. It toggles at each falling edge of the processor clock and at no other time.
- R4: The reset output goes high as soon as the reset request goes high, without waiting for a clock edge, and stays high while the request is high.
- R5: With LEN = max(MIN_RST_CLKS, TIME_RST_CLKS), the reset output falls exactly at the (LEN+2)-th processor clock rising edge after the request is released. It never falls between those edges.
- R6: A reset request that arrives while the stretch is running restarts the full interval, which is timed again from the new release.
- R7: The ready output, after processor clock rising edge k, equals the ready request sampled at rising edge k-1. It changes only at processor clock rising edges.
- R8: The ready output is forced low while the reset request is high.
- R9: When TIME_RST_CLKS is below MIN_RST_CLKS, the minimum count of 4 processor clocks sets the stretch length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator input, DIV_RATIO times the processor clock rate |
| rst_req | input | 1 | Asynchronous active-high reset request |
| rdy_req | input | 1 | Asynchronous ready request from slow devices |
| pclk | output | 1 | Processor clock, HIGH_STATES/DIV_RATIO duty |
| periph_clk | output | 1 | Peripheral clock, half the processor clock rate, 50% duty |
| rst_out | output | 1 | Stretched reset, released synchronously to the processor clock |
| rdy_out | output | 1 | Ready, synchronized to the processor clock |

## Verification
The bench builds two copies of the block side by side, driven by the same inputs. One copy uses TIME_RST_CLKS = 6, so the time-derived count sets the stretch. The other uses TIME_RST_CLKS = 2, so the minimum of 4 processor clocks takes over. These short lengths put the exact release edge, restarts during a stretch and many reset cycles within a few thousand oscillator cycles. The default divider of 3 with one high state is kept, so the bench's phase formulas test the 33% duty cycle that the processor actually sees.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;

  // Stretch length: the larger of the fixed minimum and the time-derived count
  function automatic int unsigned stretch_len(input int unsigned min_clks,
                                              input int unsigned time_clks);
    return (time_clks > min_clks) ? time_clks : min_clks;
  endfunction

  // Next divider phase, wrapping after div-1
  function automatic int unsigned phase_next(input int unsigned ph,
                                             input int unsigned div);
    return (ph >= div - 1) ? 0 : ph + 1;
  endfunction

  // Processor clock level for a phase: high in the first 'high' phases
  function automatic bit phase_high(input int unsigned ph,
                                    input int unsigned high);
    return ph < high;
  endfunction

endpackage

// File: rtl/clkrst_divider.sv
module clkrst_divider
  import clkrst_pkg::*;
#(
  parameter int unsigned DIV_RATIO   = 3,
  parameter int unsigned HIGH_STATES = 1
) (
  input  logic osc_clk,
  input  logic arst,
  output logic pclk,
  output logic periph_clk,
  output logic rise_evt,
  output logic fall_evt
);

  localparam int unsigned CW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CW-1:0] LAST_PH = CW'(DIV_RATIO - 1);

  logic [CW-1:0] phase_q;
  logic [CW-1:0] phase_nxt;
  logic          pclk_nxt;

  always_comb begin
    phase_nxt = CW'(phase_next(int'(phase_q), DIV_RATIO));
    pclk_nxt  = phase_high(int'(phase_nxt), HIGH_STATES);
  end

  // Events describe what happens to pclk at the coming oscillator edge
  assign rise_evt = !pclk && pclk_nxt;
  assign fall_evt = pclk && !pclk_nxt;

  always_ff @(posedge osc_clk or posedge arst) begin
    if (arst) begin
      phase_q <= '0;
      pclk    <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      pclk    <= pclk_nxt;
    end
  end

  always_ff @(posedge osc_clk or posedge arst) begin
    if (arst)          periph_clk <= 1'b0;
    else if (fall_evt) periph_clk <= !periph_clk;
  end

  a_r1_rise_lands: assert property (@(posedge osc_clk) disable iff (arst)
    rise_evt |=> pclk);
  a_r1_fall_lands: assert property (@(posedge osc_clk) disable iff (arst)
    fall_evt |=> !pclk);
  a_r1_phase_range: assert property (@(posedge osc_clk) disable iff (arst)
    phase_q <= LAST_PH);
  a_r3_periph_toggle: assert property (@(posedge osc_clk) disable iff (arst)
    fall_evt |=> (periph_clk != $past(periph_clk)));
  a_r3_periph_hold: assert property (@(posedge osc_clk) disable iff (arst)
    !fall_evt |=> $stable(periph_clk));

endmodule

// File: rtl/clkrst_stretch.sv
module clkrst_stretch
  import clkrst_pkg::*;
#(
  parameter int unsigned MIN_RST_CLKS  = 4,
  parameter int unsigned TIME_RST_CLKS = 250
) (
  input  logic osc_clk,
  input  logic arst,
  input  logic tick,
  output logic busy
);

  localparam int unsigned LEN = stretch_len(MIN_RST_CLKS, TIME_RST_CLKS);
  localparam int unsigned CW  = $clog2(LEN + 1);
  localparam logic [CW-1:0] RELOAD = CW'(LEN);

  logic [CW-1:0] remain_q;

  // Held at the reload value for as long as the request stays high
  always_ff @(posedge osc_clk or posedge arst) begin
    if (arst)                        remain_q <= RELOAD;
    else if (tick && remain_q != '0) remain_q <= remain_q - CW'(1);
  end

  assign busy = (remain_q != '0);

  a_r5_count_down: assert property (@(posedge osc_clk) disable iff (arst)
    (tick && busy) |=> (remain_q == $past(remain_q) - CW'(1)));
  a_r5_idle_stays: assert property (@(posedge osc_clk) disable iff (arst)
    !busy |=> !busy);
  a_r6_no_overflow: assert property (@(posedge osc_clk) disable iff (arst)
    remain_q <= RELOAD);

endmodule

// File: rtl/clkrst_sync.sv
module clkrst_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic osc_clk,
  input  logic arst,
  input  logic en,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge osc_clk or posedge arst) begin
    if (arst)    chain_q <= {STAGES{RST_VAL}};
    else if (en) chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

  a_r7_moves_on_enable: assert property (@(posedge osc_clk) disable iff (arst)
    !en |=> $stable(chain_q));

endmodule

// File: rtl/cpu_clkrst_cond.sv
module cpu_clkrst_cond #(
  parameter int unsigned DIV_RATIO     = 3,
  parameter int unsigned HIGH_STATES   = 1,
  parameter int unsigned MIN_RST_CLKS  = 4,
  parameter int unsigned TIME_RST_CLKS = 250,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic osc_clk,
  input  logic rst_req,
  input  logic rdy_req,
  output logic pclk,
  output logic periph_clk,
  output logic rst_out,
  output logic rdy_out
);

  logic rise_evt;
  logic fall_evt;
  logic stretch_busy;

  clkrst_divider #(
    .DIV_RATIO  (DIV_RATIO),
    .HIGH_STATES(HIGH_STATES)
  ) u_div (
    .osc_clk   (osc_clk),
    .arst      (rst_req),
    .pclk      (pclk),
    .periph_clk(periph_clk),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt)
  );

  clkrst_stretch #(
    .MIN_RST_CLKS (MIN_RST_CLKS),
    .TIME_RST_CLKS(TIME_RST_CLKS)
  ) u_stretch (
    .osc_clk(osc_clk),
    .arst   (rst_req),
    .tick   (rise_evt),
    .busy   (stretch_busy)
  );

  clkrst_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_rst_sync (
    .osc_clk(osc_clk),
    .arst   (rst_req),
    .en     (rise_evt),
    .d      (stretch_busy),
    .q      (rst_out)
  );

  clkrst_sync #(
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b0)
  ) u_rdy_sync (
    .osc_clk(osc_clk),
    .arst   (rst_req),
    .en     (rise_evt),
    .d      (rdy_req),
    .q      (rdy_out)
  );

  a_r4_req_forces_rst: assert property (@(posedge osc_clk)
    rst_req |-> rst_out);
  a_r5_release_on_rise: assert property (@(posedge osc_clk) disable iff (rst_req)
    $fell(rst_out) |-> $past(rise_evt));
  a_r5_release_after_stretch: assert property (@(posedge osc_clk) disable iff (rst_req)
    $fell(rst_out) |-> !stretch_busy);
  a_r7_rdy_on_rise: assert property (@(posedge osc_clk) disable iff (rst_req)
    !$past(rise_evt) |-> $stable(rdy_out));
  a_r8_rdy_low_in_reset: assert property (@(posedge osc_clk)
    rst_req |-> !rdy_out);

endmodule

// File: tb/cpu_clkrst_cond_bench.sv
module cpu_clkrst_cond_bench;

  localparam int OSC_PERIOD = 10;
  localparam int MIN_CLKS   = 4;
  localparam int TIME_A     = 6;
  localparam int TIME_B     = 2;

  function automatic int exp_len(input int mn, input int tm);
    if (tm > mn) return tm;
    return mn;
  endfunction

  // n = oscillator rising edges since the request was released
  function automatic bit exp_pclk(input int n);
    return (n > 0) && (n % 3 == 0);
  endfunction

  function automatic bit exp_periph(input int n);
    if (n < 4) return 1'b0;
    return ((n - 1) / 3) % 2 == 1;
  endfunction

  function automatic bit exp_rst(input int n, input int len);
    return (n / 3) < (len + 2);
  endfunction

  logic osc_clk = 1'b0;
  logic rst_req;
  logic rdy_req;
  logic pclk_a, periph_a, rst_a, rdy_a;
  logic pclk_b, periph_b, rst_b, rdy_b;

  int n_edges;
  bit rdy_hist;
  bit rdy_exp;
  int checks;
  int fails;

  always #(OSC_PERIOD / 2) osc_clk = ~osc_clk;

  cpu_clkrst_cond #(
    .DIV_RATIO(3), .HIGH_STATES(1), .MIN_RST_CLKS(MIN_CLKS),
    .TIME_RST_CLKS(TIME_A), .SYNC_STAGES(2)
  ) u_cpu_clkrst_cond (
    .osc_clk(osc_clk), .rst_req(rst_req), .rdy_req(rdy_req),
    .pclk(pclk_a), .periph_clk(periph_a), .rst_out(rst_a), .rdy_out(rdy_a)
  );

  cpu_clkrst_cond #(
    .DIV_RATIO(3), .HIGH_STATES(1), .MIN_RST_CLKS(MIN_CLKS),
    .TIME_RST_CLKS(TIME_B), .SYNC_STAGES(2)
  ) u_cpu_clkrst_cond_min (
    .osc_clk(osc_clk), .rst_req(rst_req), .rdy_req(rdy_req),
    .pclk(pclk_b), .periph_clk(periph_b), .rst_out(rst_b), .rdy_out(rdy_b)
  );

  task automatic check(input logic act, input logic exp, input string req,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0b expected %0b (edge %0d)",
               req, what, $time, act, exp, n_edges);
    end
  endtask

  // Reference model, advanced at each oscillator edge
  always @(posedge osc_clk) begin
    if (rst_req) begin
      n_edges  = 0;
      rdy_hist = 1'b0;
      rdy_exp  = 1'b0;
    end else begin
      n_edges++;
      if (n_edges % 3 == 0) begin
        rdy_exp  = rdy_hist;
        rdy_hist = rdy_req;
      end
    end
  end

  // Outputs sampled halfway between oscillator edges
  always @(negedge osc_clk) begin
    if (rst_req) begin
      check(pclk_a,   1'b0, "R2", "pclk low in reset");
      check(periph_a, 1'b0, "R3", "periph low in reset");
      check(rst_a,    1'b1, "R4", "rst held by request");
      check(rdy_a,    1'b0, "R8", "rdy low in reset");
      check(rst_b,    1'b1, "R4", "rst held by request (min copy)");
    end else begin
      check(pclk_a, exp_pclk(n_edges), (n_edges < 3) ? "R2" : "R1", "pclk phase");
      check(pclk_b, exp_pclk(n_edges), "R1", "pclk phase (min copy)");
      check(periph_a, exp_periph(n_edges), "R3", "periph level");
      check(periph_b, exp_periph(n_edges), "R3", "periph level (min copy)");
      check(rst_a, exp_rst(n_edges, exp_len(MIN_CLKS, TIME_A)), "R5", "rst release");
      check(rst_b, exp_rst(n_edges, exp_len(MIN_CLKS, TIME_B)), "R9", "rst minimum length");
      check(rdy_a, rdy_exp, "R7", "rdy two-stage delay");
      check(rdy_b, rdy_exp, "R7", "rdy two-stage delay (min copy)");
    end
  end

  task automatic step();
    @(negedge osc_clk);
    #2;
  endtask

  task automatic raise_reset();
    step();
    rst_req = 1'b1;
    #2;
    // R4: asserted before any oscillator edge follows
    check(rst_a, 1'b1, "R4", "async assertion");
    check(rst_b, 1'b1, "R4", "async assertion (min copy)");
    check(rdy_a, 1'b0, "R8", "async clear of ready");
  endtask

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(OSC_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary_and_end();
  end

  initial begin
    checks  = 0;
    fails   = 0;
    n_edges = 0;
    rst_req = 1'b1;
    rdy_req = 1'b0;
    void'($urandom(32'h0005_EED5));

    repeat (5) step();
    rst_req = 1'b0;
    // Directed: ready high steadily, watch first release
    rdy_req = 1'b1;
    repeat (40) step();
    rdy_req = 1'b0;
    repeat (9) step();

    // Directed R6: reassert in the middle of a stretch
    raise_reset();
    repeat (3) step();
    rst_req = 1'b0;
    repeat (12) step();
    raise_reset();
    repeat (2) step();
    rst_req = 1'b0;
    repeat (3 * (exp_len(MIN_CLKS, TIME_A) + 1)) @(posedge osc_clk);
    @(negedge osc_clk);
    check(rst_a, 1'b1, "R6", "still held one edge before release");
    repeat (3) @(posedge osc_clk);
    @(negedge osc_clk);
    check(rst_a, 1'b0, "R6", "released after restarted interval");

    // Random ready traffic with occasional reset pulses of random width
    for (int cyc = 0; cyc < 3000; cyc++) begin
      step();
      rdy_req = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 299) == 0) begin
        rst_req = 1'b1;
        #2;
        check(rst_a, 1'b1, "R4", "async assertion (random)");
        repeat ($urandom_range(1, 4)) step();
        rst_req = 1'b0;
      end
    end

    repeat (40) step();
    summary_and_end();
  end

endmodule